// File: doc/BRIEF.md
# Watchdog Timer With Interrupt Mode

This block is a watchdog that counts free-running ticks and reacts on time-out in one of three ways. It can raise an interrupt, pulse a system reset request, or do both in sequence. Software sets it up through one 8-bit control and status register. A kick input (the watchdog-reset instruction) restarts the count. An acknowledge from the interrupt vector logic clears the time-out flag, and so does a write of one to that flag.

The time-out period is a power of two of ticks, picked by a 4-bit period field. Two things are guarded against a runaway program: clearing the reset enable and changing the period. Either one needs an unlock write followed by the real write within a short window. The interrupt request is gated by a global interrupt enable input from the core. The synchronous reset `rst` is the power-on reset of the block. The block does not consume its own reset request; the system does.

Top module: `wdog_irq_timer`

## Requirements
- R1: After `rst`, the register reads 0x00, `irq_o` and `sys_rst_o` are low, and the counter is stopped.
- R2: Register layout, for both read and write: bit 7 time-out flag, bit 6 interrupt enable, bit 5 period bit 3, bit 4 change-enable (reads 1 while the change window is open), bit 3 reset enable, bits 2..0 period bits 2..0.
- R3: The counter advances only on cycles with `tick_i` high, and only while interrupt enable or reset enable is set. A time-out happens on the 2^(BASE_LOG2+P) th counted tick after the counter restarts, and the counter then restarts. With both enables clear, no time-out ever happens.
- R4: Period values above MAX_SEL (10 to 15 by default) give the same period as MAX_SEL, and they still read back unchanged.
- R5: A kick restarts the count from zero and leaves every register bit unchanged.
- R6: With interrupt enable set and reset enable clear, a time-out sets the flag and leaves interrupt enable set.
- R7: `irq_o` is high exactly when `gie_i` is high, the flag is set, and either interrupt enable is set or the flag was set by the first time-out of combined mode.
- R8: The flag is cleared by `irq_ack_i` and by a register write with bit 7 at one. A write with bit 7 at zero leaves the flag unchanged.
- R9: With reset enable set and interrupt enable clear, a time-out drives `sys_rst_o` high for exactly one cycle, in the cycle after the time-out tick.
- R10: With both enables set, the first time-out sets the flag and clears interrupt enable, while `irq_o` stays requested. The next time-out pulses `sys_rst_o`.
- R11: A write can always set reset enable, and it always updates interrupt enable. Clearing reset enable or changing the period takes effect only if the write comes on one of the WIN_CYCLES (4) cycles after a write with bits 4 and 3 both one. Outside that window those changes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_i | input | 1 | Free-running time base, one count per high cycle |
| kick_i | input | 1 | Software kick; restarts the count |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| gie_i | input | 1 | Global interrupt enable from the core |
| irq_ack_i | input | 1 | Vector logic has taken the watchdog interrupt |
| rd_data_o | output | 8 | Current register contents |
| irq_o | output | 1 | Watchdog interrupt request (level) |
| sys_rst_o | output | 1 | System reset request (one-cycle pulse) |

## Verification
A wrong count or a wrong period selection shows up as a reset pulse or an interrupt rising on the wrong cycle. The bench predicts the exact cycle of each such event from the tick pattern, so any slip of one tick is caught at the cycle where it happens. A wrong flag, enable or window state shows on the register read-back one cycle after the write or acknowledge that should have changed it. It also shows on the level of `irq_o` in that same cycle. The gate and boundary cases covered are the fourth and fifth cycle after unlock, a reserved period, and a flag left set with its enable cleared.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int SEL_W  = 4;
    localparam int DATA_W = 8;

    // Register image; field order is the bit layout (msb first).
    typedef struct packed {
        logic       flag;
        logic       ie;
        logic       sel_hi;
        logic       chg;
        logic       re;
        logic [2:0] sel_lo;
    } wdog_reg_t;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_IRQ  = 2'b01,
        MODE_RST  = 2'b10,
        MODE_BOTH = 2'b11
    } wdog_mode_e;

    function automatic wdog_mode_e mode_of(logic ie, logic re);
        return wdog_mode_e'({re, ie});
    endfunction

    function automatic logic [SEL_W-1:0] clamp_sel(logic [SEL_W-1:0] s, int max_sel);
        if (int'(s) > max_sel)
            return SEL_W'(max_sel);
        return s;
    endfunction

endpackage

// File: rtl/wdog_csr.sv
module wdog_csr
    import wdog_pkg::*;
#(
    parameter int WIN_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              hw_ie_clr_i,
    input  logic              flag_i,
    output logic              w1c_o,
    output logic              ie_o,
    output logic              re_o,
    output logic [SEL_W-1:0]  sel_o,
    output wdog_reg_t         reg_o
);
    localparam int WIN_W = $clog2(WIN_CYCLES + 1);

    wdog_reg_t        wd;
    logic             ie_q, re_q;
    logic [SEL_W-1:0] sel_q;
    logic [WIN_W-1:0] win_q;
    logic             win_open;
    logic             unlock;

    assign wd       = wdog_reg_t'(wr_data_i);
    assign unlock   = wd.chg & wd.re;
    assign win_open = (win_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q  <= 1'b0;
            re_q  <= 1'b0;
            sel_q <= '0;
            win_q <= '0;
        end else begin
            if (wr_en_i) begin
                ie_q <= wd.ie;
                if (win_open) begin
                    re_q  <= wd.re;
                    sel_q <= {wd.sel_hi, wd.sel_lo};
                    win_q <= '0;
                end else begin
                    re_q  <= re_q | wd.re;
                    win_q <= unlock ? WIN_W'(WIN_CYCLES) : '0;
                end
            end else if (win_open) begin
                win_q <= win_q - 1'b1;
            end
            if (hw_ie_clr_i)
                ie_q <= 1'b0;
        end
    end

    assign w1c_o = wr_en_i & wd.flag;
    assign ie_o  = ie_q;
    assign re_o  = re_q;
    assign sel_o = sel_q;

    always_comb begin
        reg_o        = '0;
        reg_o.flag   = flag_i;
        reg_o.ie     = ie_q;
        reg_o.sel_hi = sel_q[3];
        reg_o.chg    = win_open;
        reg_o.re     = re_q;
        reg_o.sel_lo = sel_q[2:0];
    end

    // R11: locked writes cannot move the period
    a_r11_sel_locked: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !win_open) |=> (sel_q == $past(sel_q)));

    // R11: locked writes cannot clear the reset enable
    a_r11_re_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !win_open && re_q) |=> re_q);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int MAX_SEL   = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             kick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             timeout_o
);
    localparam int CNT_W = BASE_LOG2 + MAX_SEL;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic [SEL_W-1:0] sel_c;

    always_comb begin
        sel_c    = clamp_sel(sel_i, MAX_SEL);
        last_cnt = {CNT_W{1'b1}} >> (MAX_SEL - int'(sel_c));
    end

    // A shortened period takes effect at once: any count at or past the end fires.
    assign timeout_o = run_i & tick_i & ~kick_i & (cnt_q >= last_cnt);

    always_ff @(posedge clk) begin
        if (rst || !run_i || kick_i)
            cnt_q <= '0;
        else if (tick_i)
            cnt_q <= timeout_o ? '0 : cnt_q + 1'b1;
    end

    // R5: a kick restarts the count
    a_r5_kick_restart: assert property (@(posedge clk) disable iff (rst)
        kick_i |=> (cnt_q == '0));

    // R3: the count restarts after a time-out
    a_r3_restart_after_timeout: assert property (@(posedge clk) disable iff (rst)
        timeout_o |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_event.sv
module wdog_event
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic timeout_i,
    input  logic ie_i,
    input  logic re_i,
    input  logic gie_i,
    input  logic ack_i,
    input  logic w1c_i,
    output logic flag_o,
    output logic ie_clr_o,
    output logic irq_o,
    output logic sys_rst_o
);
    wdog_mode_e mode;
    logic       set_flag, escalate, rst_req, clr_flag;
    logic       flag_q, esc_q, rst_q;

    always_comb begin
        mode     = mode_of(ie_i, re_i);
        set_flag = 1'b0;
        escalate = 1'b0;
        rst_req  = 1'b0;
        case (mode)
            MODE_IRQ:  set_flag = timeout_i;
            MODE_RST:  rst_req  = timeout_i;
            MODE_BOTH: begin
                set_flag = timeout_i;
                escalate = timeout_i;
            end
            default: ;
        endcase
    end

    assign clr_flag = ack_i | w1c_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            esc_q  <= 1'b0;
            rst_q  <= 1'b0;
        end else begin
            rst_q <= rst_req;
            if (set_flag)
                flag_q <= 1'b1;
            else if (clr_flag)
                flag_q <= 1'b0;
            if (escalate)
                esc_q <= 1'b1;
            else if (clr_flag)
                esc_q <= 1'b0;
        end
    end

    assign flag_o    = flag_q;
    assign ie_clr_o  = escalate;
    assign irq_o     = gie_i & flag_q & (ie_i | esc_q);
    assign sys_rst_o = rst_q;

    // R9: reset request lasts one cycle
    a_r9_rst_single: assert property (@(posedge clk) disable iff (rst)
        sys_rst_o |=> !sys_rst_o);

    // R8: acknowledge or write-one clears the flag
    a_r8_clear_flag: assert property (@(posedge clk) disable iff (rst)
        (clr_flag && !timeout_i) |=> !flag_q);

    // R10: first combined time-out raises flag and drops the enable
    a_r10_escalate: assert property (@(posedge clk) disable iff (rst)
        (timeout_i && ie_i && re_i) |=> (flag_q && !ie_i && irq_o == gie_i));

    // R7: no request without global enable and flag
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (gie_i && flag_q));

endmodule

// File: rtl/wdog_irq_timer.sv
module wdog_irq_timer
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2  = 11,
    parameter int MAX_SEL    = 9,
    parameter int WIN_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       kick_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    input  logic       gie_i,
    input  logic       irq_ack_i,
    output logic [7:0] rd_data_o,
    output logic       irq_o,
    output logic       sys_rst_o
);
    logic             ie, re, flag, w1c, ie_clr, timeout;
    logic [SEL_W-1:0] sel;
    wdog_reg_t        reg_view;

    wdog_csr #(.WIN_CYCLES(WIN_CYCLES)) csr_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .hw_ie_clr_i(ie_clr),
        .flag_i     (flag),
        .w1c_o      (w1c),
        .ie_o       (ie),
        .re_o       (re),
        .sel_o      (sel),
        .reg_o      (reg_view)
    );

    wdog_counter #(.BASE_LOG2(BASE_LOG2), .MAX_SEL(MAX_SEL)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .run_i    (ie | re),
        .tick_i   (tick_i),
        .kick_i   (kick_i),
        .sel_i    (sel),
        .timeout_o(timeout)
    );

    wdog_event evt_i (
        .clk      (clk),
        .rst      (rst),
        .timeout_i(timeout),
        .ie_i     (ie),
        .re_i     (re),
        .gie_i    (gie_i),
        .ack_i    (irq_ack_i),
        .w1c_i    (w1c),
        .flag_o   (flag),
        .ie_clr_o (ie_clr),
        .irq_o    (irq_o),
        .sys_rst_o(sys_rst_o)
    );

    assign rd_data_o = reg_view;

    // R3: with both enables clear nothing is requested
    a_r3_off_silent: assert property (@(posedge clk) disable iff (rst)
        (!ie && !re) |=> !sys_rst_o);

endmodule

// File: tb/wdog_irq_timer_tb_top.sv
module wdog_irq_timer_tb_top;
    localparam int BASE = 2;
    localparam int MAXS = 9;
    localparam int WIN  = 4;
    localparam int K_IRQ = 0;
    localparam int K_RST = 1;

    logic       clk = 0, rst = 1, tick = 0, kick = 0, wr_en = 0, gie = 0, ack = 0;
    logic [7:0] wdata = '0;
    logic [7:0] rd_data;
    logic       irq, sys_rst;

    wdog_irq_timer #(.BASE_LOG2(BASE), .MAX_SEL(MAXS), .WIN_CYCLES(WIN)) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick), .kick_i(kick), .wr_en_i(wr_en),
        .wr_data_i(wdata), .gie_i(gie), .irq_ack_i(ack),
        .rd_data_o(rd_data), .irq_o(irq), .sys_rst_o(sys_rst)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int kind; int at; string req; } ev_t;
    ev_t expq[$];
    int  checks = 0, errors = 0;
    bit  done = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_ev(int kind, int at, string req);
        ev_t e;
        e.kind = kind; e.at = at; e.req = req;
        expq.push_back(e);
    endtask

    // Monitor: pops one expected event per observed event
    task automatic observe(int kind);
        ev_t e;
        if (expq.size() == 0) begin
            chk(0, "R3", "unexpected event kind", kind, -1);
        end else begin
            e = expq.pop_front();
            chk(e.kind == kind, e.req, "event kind", kind, e.kind);
            chk(e.at == cyc, e.req, "event cycle", cyc, e.at);
        end
    endtask

    logic irq_prev = 0;
    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            if (sys_rst) observe(K_RST);
            if (irq && !irq_prev) observe(K_IRQ);
        end
        irq_prev = irq;
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wr(logic [7:0] d);
        wr_en = 1; wdata = d; @(negedge clk); wr_en = 0;
    endtask
    task automatic do_kick();
        kick = 1; @(negedge clk); kick = 0;
    endtask
    task automatic ticks(int n);
        tick = 1; repeat (n) @(negedge clk); tick = 0;
    endtask
    task automatic chk_reg(logic [7:0] exp, string req, string what);
        #1 chk(rd_data == exp, req, what, rd_data, exp);
    endtask

    initial begin
        #(8 * 200000);
        chk(0, "R3", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t;
        step(3);
        rst = 0;
        // R1 reset state
        chk_reg(8'h00, "R1", "reset register");
        chk(irq == 0 && sys_rst == 0, "R1", "reset outputs", {irq, sys_rst}, 0);
        ticks(20);                      // R1/R3: stopped counter, no events

        // R11 set reset enable freely; R9 reset-only pulses, period 4
        wr(8'h08);
        chk_reg(8'h08, "R11", "set re without unlock");
        expect_ev(K_RST, cyc + 4, "R9"); ticks(4);
        expect_ev(K_RST, cyc + 4, "R9"); ticks(4);
        step(1);
        chk(sys_rst == 0, "R9", "pulse width", sys_rst, 0);

        // R11 protection
        wr(8'h00); chk_reg(8'h08, "R11", "locked clear of re");
        wr(8'h0B); chk_reg(8'h08, "R11", "locked period change");
        wr(8'h18); chk_reg(8'h18, "R2", "window bit open");
        step(4);   chk_reg(8'h08, "R2", "window bit closed");
        wr(8'h03); chk_reg(8'h08, "R11", "write on fifth cycle ignored");
        wr(8'h18); step(3);
        wr(8'h0B); chk_reg(8'h0B, "R11", "write on fourth cycle taken");

        // R3 period P=3 -> 32 ticks, with gaps in the tick stream
        do_kick();
        expect_ev(K_RST, cyc + 32, "R3"); ticks(32);
        t = cyc + 10 + 5 + 22;
        expect_ev(K_RST, t, "R3"); ticks(10); step(5); ticks(22);
        // R5 kick restarts mid-way
        ticks(20); do_kick();
        chk_reg(8'h0B, "R5", "kick leaves config");
        expect_ev(K_RST, cyc + 32, "R5"); ticks(32);

        // R4 reserved period 12 behaves as 9 -> 2048 ticks
        wr(8'h18); wr(8'h2C);
        chk_reg(8'h2C, "R4", "reserved readback");
        do_kick();
        expect_ev(K_RST, cyc + 2048, "R4"); ticks(2048);

        // R6/R7/R8 interrupt-only, period 4
        wr(8'h18); wr(8'h40);
        chk_reg(8'h40, "R11", "clear re via window");
        do_kick();
        ticks(4);
        chk_reg(8'hC0, "R6", "flag set, ie kept");
        chk(irq == 0, "R7", "gated by gie", irq, 0);
        expect_ev(K_IRQ, cyc, "R7");
        gie = 1;
        #1 chk(irq == 1, "R7", "irq with gie", irq, 1);
        wr(8'h40); chk_reg(8'hC0, "R8", "write zero keeps flag");
        ack = 1; step(1); ack = 0;
        chk_reg(8'h40, "R8", "ack clears flag");
        chk(irq == 0, "R8", "irq after ack", irq, 0);
        expect_ev(K_IRQ, cyc + 4, "R6"); ticks(4);
        chk_reg(8'hC0, "R6", "second flag");
        wr(8'hC0); chk_reg(8'h40, "R8", "write one clears flag");
        chk(irq == 0, "R8", "irq after w1c", irq, 0);
        expect_ev(K_IRQ, cyc + 4, "R6"); ticks(4);
        wr(8'h00); chk_reg(8'h80, "R7", "ie cleared, flag kept");
        chk(irq == 0, "R7", "no irq without ie", irq, 0);
        wr(8'h80); chk_reg(8'h00, "R8", "flag cleared");
        ticks(50);
        chk(irq == 0 && sys_rst == 0, "R3", "disabled stays silent", {irq, sys_rst}, 0);

        // R10 combined mode
        wr(8'h48); chk_reg(8'h48, "R10", "both enables");
        do_kick();
        expect_ev(K_IRQ, cyc + 4, "R10"); ticks(4);
        chk_reg(8'h88, "R10", "flag set, ie dropped");
        chk(irq == 1, "R10", "irq held", irq, 1);
        ack = 1; step(1); ack = 0;
        chk_reg(8'h08, "R10", "after ack");
        chk(irq == 0, "R10", "irq after ack", irq, 0);
        expect_ev(K_RST, cyc + 4, "R10"); ticks(4);

        step(3);
        chk(expq.size() == 0, "R3", "missing events", expq.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule